// File: doc/BRIEF.md
# External Interrupt Pending Register

This block holds the external interrupts posted to one processor core, along with the mask that decides which of them reach the core. Any agent on the system bus can post an interrupt by writing a bit number to the block's word. The number counts from the most significant end, so a written number of 0 selects the top bit. A local interval timer posts interrupt 0 through its own pulse input. The core's control-register port removes handled interrupts by writing a 1 to each bit it wants cleared, and loads the whole mask in one write.

The request line to the core is a registered level. It is high while at least one pending bit is also enabled in the mask. The register width is a parameter, 32 or 64. The bus data path has the same width, and the bus accepts only single aligned 4-byte accesses. For each access the strobe pattern must enable exactly one aligned 4-byte lane. Bus reads return the pending register one cycle after the access.

Top module: `ext_irq_pending`

## Requirements
- R1: A bus write with a legal word strobe sets exactly one pending bit. Let d be the value held by the enabled 32-bit lane of the write data. The bit set is at physical position W-1-(d mod W), where W is the register width. So d=0 sets bit W-1, and d=W-1 sets bit 0.
- R2: A bus access whose byte-enable pattern is not exactly one aligned group of four enabled bytes (4'hF in the 32-bit build) leaves the pending register unchanged, and a read of that kind returns zero.
- R3: A bus read with a legal strobe returns, one cycle later on the read data port, the pending value from before that cycle's update. The read itself changes nothing.
- R4: A control-port write to the pending register clears each bit written as 1 and keeps each bit written as 0.
- R5: A control-port write to the mask replaces all of its bits. The mask holds its value at other times.
- R6: The request output equals the OR of (pending AND mask) as registered one clock earlier. It therefore changes two edges after the write that alters pending or mask.
- R7: A timer pulse sets the most significant pending bit (interrupt 0).
- R8: If a set (from a bus post or the timer) and a clear hit the same bit in one cycle, the bit ends up set.
- R9: After a synchronous active-low reset, the pending register, the mask, the request output and the read data are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Bus access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write (post an interrupt), 0 = read |
| bus_be | input | REG_W/8 | Byte enables of the access |
| bus_wdata | input | REG_W | Bus write data; the enabled lane carries the bit number |
| bus_rdata | output | REG_W | Registered read data (pending value, or zero for an illegal strobe) |
| cpu_wr_pend | input | 1 | Control-port write that clears pending bits |
| cpu_wr_mask | input | 1 | Control-port write that loads the mask |
| cpu_wdata | input | REG_W | Control-port write value |
| timer_alarm | input | 1 | One-cycle timer pulse that posts interrupt 0 |
| pend_q | output | REG_W | Current pending register |
| mask_q | output | REG_W | Current mask register |
| irq_req | output | 1 | Level interrupt request to the core |

## Verification
The hardest situation to reach is a collision: a set and a clear of the same bit in one cycle. From the outside this only happens when a bus post or a timer pulse lands on the same clock edge as a control-port clear that covers the same bit. The bench drives both inputs from a single task on one falling edge. It does this twice, once with a bus post and once with a timer pulse, each against an all-ones clear. It then checks that only the posted bit survives. The registered lag of the request line is a related timing case. The bench samples it both one and two edges after a mask write to confirm the extra register stage.

// File: rtl/eirr_pkg.sv
// Package: shared constants and types for the external interrupt pending block.
// Assumes bus lanes are 32 bits wide and carry one byte enable per byte.
package eirr_pkg;
    localparam int LANE_BITS  = 32;
    localparam int LANE_BYTES = LANE_BITS / 8;

    // Decoded kind of bus access in the current cycle
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } bus_op_e;
endpackage

// File: rtl/eirr_bus_port.sv
// Bus slave port: decodes a word access, turns a posted bit number into a
// one-hot set vector, and registers read data.
// Assumes REG_W is a multiple of 32 and a power of two; one access per cycle.
module eirr_bus_port
    import eirr_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [REG_W/8-1:0] bus_be,
    input  logic [REG_W-1:0]   bus_wdata,
    input  logic [REG_W-1:0]   pend_q,
    output logic [REG_W-1:0]   post_vec,
    output logic [REG_W-1:0]   bus_rdata
);
    localparam int LANES = REG_W / LANE_BITS;
    localparam int BE_W  = REG_W / 8;
    localparam int IDX_W = $clog2(REG_W);

    logic [LANES-1:0]     lane_hit;
    logic [LANE_BITS-1:0] lane_word;
    logic                 be_ok;
    logic [IDX_W-1:0]     bit_idx;
    bus_op_e              op;

    // One legal strobe pattern per aligned lane
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_hit[g] = (bus_be == (BE_W'({LANE_BYTES{1'b1}}) << (LANE_BYTES * g)));
    end

    assign be_ok = |lane_hit;

    // Purpose: classify the access in this cycle
    always_comb begin
        if (!bus_valid)     op = OP_IDLE;
        else if (bus_write) op = OP_WRITE;
        else                op = OP_READ;
    end

    // Purpose: gather the data word of the enabled lane
    always_comb begin
        lane_word = '0;
        for (int l = 0; l < LANES; l++) begin
            if (lane_hit[l]) lane_word = lane_word | bus_wdata[LANE_BITS*l +: LANE_BITS];
        end
    end

    // Purpose: complement of the number modulo width gives the physical bit
    always_comb begin
        bit_idx = IDX_W'((~lane_word) % LANE_BITS'(REG_W));
    end

    // Purpose: one-hot set request for a legal posting write
    always_comb begin
        post_vec = '0;
        if (op == OP_WRITE && be_ok) post_vec[bit_idx] = 1'b1;
    end

    // Purpose: register read data; illegal strobes read as zero
    always_ff @(posedge clk) begin
        if (!rst_n)                bus_rdata <= '0;
        else if (op == OP_READ)    bus_rdata <= be_ok ? pend_q : '0;
    end

    a_r1_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(post_vec));
    a_r2_bad_be_no_post: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !be_ok) |-> (post_vec == '0));
    a_r2_bad_be_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && !be_ok) |=> (bus_rdata == '0));
    a_r3_read_returns_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && be_ok) |=> (bus_rdata == $past(pend_q)));
endmodule

// File: rtl/eirr_pending.sv
// Pending register: collects bus posts and timer pulses, and clears bits
// named by a control-port write. Sets win over clears on the same bit.
// Assumes at most one bus post per cycle; the timer owns the top bit.
module eirr_pending #(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] post_vec,
    input  logic             timer_alarm,
    input  logic             clr_en,
    input  logic [REG_W-1:0] clr_val,
    output logic [REG_W-1:0] pend_q
);
    localparam int TOP = REG_W - 1;

    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] clr_vec;
    logic [REG_W-1:0] pend_n;

    // Purpose: merge the two sources of new interrupts
    always_comb begin
        set_vec      = post_vec;
        set_vec[TOP] = post_vec[TOP] | timer_alarm;
    end

    // Purpose: clear mask is active only on a control-port write
    always_comb begin
        clr_vec = clr_en ? clr_val : '0;
    end

    // Purpose: clear first, then set, so posted bits are never lost
    always_comb begin
        pend_n = (pend_q & ~clr_vec) | set_vec;
    end

    // Purpose: state register
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_n;
    end

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));
    a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((pend_q & $past(clr_val & ~set_vec)) == '0));
    a_r4_keeps_others: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(pend_q & ~clr_vec)) == $past(pend_q & ~clr_vec)));
    a_r7_timer_top: assert property (@(posedge clk) disable iff (!rst_n)
        timer_alarm |=> pend_q[TOP]);
endmodule

// File: rtl/eirr_mask.sv
// Enable mask: loaded whole by a control-port write, otherwise held.
// Assumes no partial-write semantics on the control port.
module eirr_mask #(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [REG_W-1:0] load_val,
    output logic [REG_W-1:0] mask_q
);
    // Purpose: replace the mask on a write
    always_ff @(posedge clk) begin
        if (!rst_n)    mask_q <= '0;
        else if (load) mask_q <= load_val;
    end

    a_r5_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (mask_q == $past(load_val)));
    a_r5_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(mask_q));
endmodule

// File: rtl/eirr_req.sv
// Request generator: registers the OR of enabled pending bits as a level
// to the core. Assumes the core tolerates one cycle of extra latency.
module eirr_req #(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] pend_q,
    input  logic [REG_W-1:0] mask_q,
    output logic             irq_req
);
    logic live;

    // Purpose: any pending bit that is also enabled
    always_comb begin
        live = |(pend_q & mask_q);
    end

    // Purpose: registered level output
    always_ff @(posedge clk) begin
        if (!rst_n) irq_req <= 1'b0;
        else        irq_req <= live;
    end

    a_r6_req_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq_req == (($past(pend_q) & $past(mask_q)) != '0)));
    a_r6_no_req_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |=> !irq_req);
endmodule

// File: rtl/ext_irq_pending.sv
// Top: per-core external interrupt pending register with enable mask,
// a system-bus posting port, a control-register port and a timer input.
// Assumes REG_W is 32 or 64 and the bus issues single-cycle accesses.
module ext_irq_pending #(
    parameter int REG_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [REG_W/8-1:0] bus_be,
    input  logic [REG_W-1:0]   bus_wdata,
    output logic [REG_W-1:0]   bus_rdata,
    input  logic               cpu_wr_pend,
    input  logic               cpu_wr_mask,
    input  logic [REG_W-1:0]   cpu_wdata,
    input  logic               timer_alarm,
    output logic [REG_W-1:0]   pend_q,
    output logic [REG_W-1:0]   mask_q,
    output logic               irq_req
);
    logic [REG_W-1:0] post_vec;

    eirr_bus_port #(.REG_W(REG_W)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .pend_q    (pend_q),
        .post_vec  (post_vec),
        .bus_rdata (bus_rdata)
    );

    eirr_pending #(.REG_W(REG_W)) u_pend (
        .clk         (clk),
        .rst_n       (rst_n),
        .post_vec    (post_vec),
        .timer_alarm (timer_alarm),
        .clr_en      (cpu_wr_pend),
        .clr_val     (cpu_wdata),
        .pend_q      (pend_q)
    );

    eirr_mask #(.REG_W(REG_W)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cpu_wr_mask),
        .load_val (cpu_wdata),
        .mask_q   (mask_q)
    );

    eirr_req #(.REG_W(REG_W)) u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend_q  (pend_q),
        .mask_q  (mask_q),
        .irq_req (irq_req)
    );

    a_r9_reset_clean: assert property (@(posedge clk)
        !rst_n |=> (pend_q == '0 && mask_q == '0 && !irq_req && bus_rdata == '0));
endmodule

// File: tb/ext_irq_pending_test.sv
`timescale 1ns/1ps
module ext_irq_pending_test;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_valid = 1'b0;
    logic         bus_write = 1'b0;
    logic [3:0]   bus_be = '0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic         cpu_wr_pend = 1'b0;
    logic         cpu_wr_mask = 1'b0;
    logic [W-1:0] cpu_wdata = '0;
    logic         timer_alarm = 1'b0;
    logic [W-1:0] pend_q;
    logic [W-1:0] mask_q;
    logic         irq_req;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    ext_irq_pending #(.REG_W(W)) uut (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpu_wr_pend(cpu_wr_pend), .cpu_wr_mask(cpu_wr_mask), .cpu_wdata(cpu_wdata),
        .timer_alarm(timer_alarm),
        .pend_q(pend_q), .mask_q(mask_q), .irq_req(irq_req)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Inputs change only on falling edges; results are sampled on falling edges
    task automatic bus_post(input logic [3:0] be, input logic [W-1:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_be = '0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [3:0] be);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_be = be;
        @(negedge clk);
        bus_valid = 1'b0; bus_be = '0;
    endtask

    task automatic cpu_clear(input logic [W-1:0] v);
        @(negedge clk);
        cpu_wr_pend = 1'b1; cpu_wdata = v;
        @(negedge clk);
        cpu_wr_pend = 1'b0; cpu_wdata = '0;
    endtask

    task automatic cpu_mask(input logic [W-1:0] v);
        @(negedge clk);
        cpu_wr_mask = 1'b1; cpu_wdata = v;
        @(negedge clk);
        cpu_wr_mask = 1'b0; cpu_wdata = '0;
    endtask

    task automatic t_reset;
        chk("R9 pending", pend_q, '0);
        chk("R9 mask", mask_q, '0);
        chk("R9 irq", W'(irq_req), '0);
        chk("R9 rdata", bus_rdata, '0);
    endtask

    task automatic t_post;
        logic [W-1:0] vals [4] = '{32'd0, 32'd31, 32'd5, 32'd37};
        for (int i = 0; i < 4; i++) begin
            cpu_clear('1);
            bus_post(4'hF, vals[i]);
            chk("R1 post bit", pend_q, W'(1) << (W - 1 - (vals[i] % W)));
        end
        chk("R6 masked no irq", W'(irq_req), '0);
    endtask

    task automatic t_bad_be;
        cpu_clear('1);
        bus_post(4'h3, 32'd0);
        chk("R2 bad strobe write ignored", pend_q, '0);
        bus_post(4'hF, 32'd2);
        bus_read(4'h3);
        chk("R2 bad strobe read zero", bus_rdata, '0);
        chk("R2 pending intact", pend_q, 32'h2000_0000);
    endtask

    task automatic t_read;
        cpu_clear('1);
        bus_post(4'hF, 32'd3);
        bus_read(4'hF);
        chk("R3 read data", bus_rdata, 32'h1000_0000);
        chk("R3 read no side effect", pend_q, 32'h1000_0000);
    endtask

    task automatic t_clear;
        cpu_clear('1);
        bus_post(4'hF, 32'd31);
        bus_post(4'hF, 32'd30);
        bus_post(4'hF, 32'd29);
        chk("R1 three posts", pend_q, 32'h7);
        cpu_clear(32'h5);
        chk("R4 selective clear", pend_q, 32'h2);
    endtask

    task automatic t_mask_irq;
        cpu_mask(32'h2);
        chk("R5 mask loaded", mask_q, 32'h2);
        chk("R6 irq lags one edge", W'(irq_req), '0);
        @(negedge clk);
        chk("R6 irq rises", W'(irq_req), 32'h1);
        chk("R5 mask held", mask_q, 32'h2);
        cpu_mask(32'h4);
        chk("R5 mask replaced", mask_q, 32'h4);
        chk("R6 irq still high one edge", W'(irq_req), 32'h1);
        @(negedge clk);
        chk("R6 irq falls", W'(irq_req), '0);
        cpu_mask('0);
    endtask

    task automatic t_timer;
        cpu_clear('1);
        @(negedge clk);
        timer_alarm = 1'b1;
        @(negedge clk);
        timer_alarm = 1'b0;
        chk("R7 timer top bit", pend_q, 32'h8000_0000);
    endtask

    task automatic t_collide;
        cpu_clear('1);
        bus_post(4'hF, 32'd30);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_be = 4'hF; bus_wdata = 32'd4;
        cpu_wr_pend = 1'b1; cpu_wdata = '1;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_be = '0; bus_wdata = '0;
        cpu_wr_pend = 1'b0; cpu_wdata = '0;
        chk("R8 bus post beats clear", pend_q, 32'h0800_0000);
        @(negedge clk);
        timer_alarm = 1'b1; cpu_wr_pend = 1'b1; cpu_wdata = '1;
        @(negedge clk);
        timer_alarm = 1'b0; cpu_wr_pend = 1'b0; cpu_wdata = '0;
        chk("R8 timer beats clear", pend_q, 32'h8000_0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_post();
        t_bad_be();
        t_read();
        t_clear();
        t_mask_irq();
        t_timer();
        t_collide();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule